// File: doc/BRIEF.md
# USART control-write sequencer

This block sits behind the control address of a serial controller and decides what each CPU control write means. A small entry machine orders the writes: the first one after reset is the mode word, then zero, one or two sync characters depending on that mode word, and after that every control write is a command. A command with its internal-reset bit set returns the machine to mode entry, so software can reprogram the framing without a hardware reset.

The stored mode word is decoded into framing settings for the serial shifters: character length, parity enable and sense, stop-bit code, clock factor, synchronous or asynchronous operation, the sync-character count and the external-sync select. The stored sync pattern, the last command byte and a hunt-mode flag are also driven out. The serial shifters, modem lines and data register path are not part of this block. Writes at the data address are not decoded here.

Top module: `usart_ctl_seq`

## Requirements
- R1: After reset `entry_state` is 1 (mode entry; the encoding is 0 command, 1 mode, 2 first sync, 3 second sync), `hunt` is 0, `cmd` is 0 and `sync_pat` is 0.
- R2: A write with `addr` = 0 changes no output.
- R3: Mode bits [1:0] = 00 give `sync_mode` = 1 and `clk_factor` = 1; codes 01, 10, 11 give `sync_mode` = 0 and `clk_factor` 1, 16 and 64.
- R4: `char_len` equals mode bits [3:2] plus 5.
- R5: `par_en` follows mode bit 4 and `par_even` follows mode bit 5.
- R6: In asynchronous mode `stop_code` follows mode bits [7:6] (00 inhibit, 01 one, 10 one and a half, 11 two) and is 00 in synchronous mode; an asynchronous mode write moves `entry_state` to 0.
- R7: A synchronous mode write sets `ext_sync` from bit 6; with bit 7 set `sync_single` is 1 and `entry_state` moves to 3, with bit 7 clear `sync_single` is 0 and `entry_state` moves to 2.
- R8: A write in state 2 loads `sync_pat[15:8]` and moves to state 3; a write in state 3 loads `sync_pat[7:0]` and moves to state 0.
- R9: A write in state 0 loads `cmd`; if data bit 6 is set `entry_state` moves to 1, otherwise it stays 0.
- R10: A command write sets `hunt` to data bit 7 when `sync_mode` is 1 and to 0 otherwise; a mode write clears `hunt`.
- R11: A mode write clears `sync_pat` to 0, so a single-sync pattern appears in `sync_pat[7:0]` with the upper byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 1 | 1 selects control, 0 selects data |
| wdata | input | 8 | Write data |
| entry_state | output | 2 | Which register the next control write goes to |
| sync_mode | output | 1 | Synchronous operation selected |
| char_len | output | 4 | Bits per character, 5 to 8 |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity when 1, odd when 0 |
| stop_code | output | 2 | Stop-bit code |
| clk_factor | output | 7 | Clock division factor 1, 16 or 64 |
| sync_single | output | 1 | One sync character instead of two |
| ext_sync | output | 1 | External sync detect selected |
| sync_pat | output | 16 | Stored sync pattern |
| cmd | output | 8 | Last command byte |
| hunt | output | 1 | Hunt mode active |

## Verification
The properties assume each write is a single-cycle strobe with `addr` and `wdata` stable across that edge, and that nothing is written during reset. The bench drives every write from a task that raises `wr_en` for exactly one clock with data set up half a period earlier, and keeps the strobe low while reset is asserted. It sweeps all 256 mode words, walking each through its sync entries and commands and returning to mode entry by an internal-reset command, so the sequence never leaves the legal write order.

// File: rtl/usart_ctl_seq.sv
module usart_ctl_seq #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           addr,
  input  logic [W-1:0]   wdata,
  output logic [1:0]     entry_state,
  output logic           sync_mode,
  output logic [3:0]     char_len,
  output logic           par_en,
  output logic           par_even,
  output logic [1:0]     stop_code,
  output logic [6:0]     clk_factor,
  output logic           sync_single,
  output logic           ext_sync,
  output logic [2*W-1:0] sync_pat,
  output logic [W-1:0]   cmd,
  output logic           hunt
);
  localparam logic [1:0] ST_CMD  = 2'd0;
  localparam logic [1:0] ST_MODE = 2'd1;
  localparam logic [1:0] ST_SYN1 = 2'd2;
  localparam logic [1:0] ST_SYN2 = 2'd3;

  logic [1:0]     st_q;
  logic [W-1:0]   mode_q;
  logic [W-1:0]   cmd_q;
  logic [2*W-1:0] pat_q;
  logic           hunt_q;

  wire ctl_wr  = wr_en & addr;
  wire is_sync = (mode_q[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_MODE;
      mode_q <= '0;
      cmd_q  <= '0;
      pat_q  <= '0;
      hunt_q <= 1'b0;
    end else if (ctl_wr) begin
      case (st_q)
        ST_MODE: begin
          mode_q <= wdata;
          pat_q  <= '0;
          hunt_q <= 1'b0;
          if (wdata[1:0] != 2'b00) st_q <= ST_CMD;
          else if (wdata[7])       st_q <= ST_SYN2;
          else                     st_q <= ST_SYN1;
        end
        ST_SYN1: begin
          pat_q[2*W-1:W] <= wdata;
          st_q <= ST_SYN2;
        end
        ST_SYN2: begin
          pat_q[W-1:0] <= wdata;
          st_q <= ST_CMD;
        end
        default: begin
          cmd_q  <= wdata;
          hunt_q <= is_sync & wdata[7];
          if (wdata[6]) st_q <= ST_MODE;
        end
      endcase
    end
  end

  assign entry_state = st_q;
  assign sync_mode   = is_sync;
  assign char_len    = {2'b00, mode_q[3:2]} + 4'd5;
  assign par_en      = mode_q[4];
  assign par_even    = mode_q[5];
  assign stop_code   = is_sync ? 2'b00 : mode_q[7:6];
  assign sync_single = is_sync & mode_q[7];
  assign ext_sync    = is_sync & mode_q[6];
  assign sync_pat    = pat_q;
  assign cmd         = cmd_q;
  assign hunt        = hunt_q;

  always_comb begin
    case (mode_q[1:0])
      2'b10:   clk_factor = 7'd16;
      2'b11:   clk_factor = 7'd64;
      default: clk_factor = 7'd1;
    endcase
  end
endmodule

module usart_ctl_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        addr,
  input logic [7:0]  wdata,
  input logic [1:0]  entry_state,
  input logic        sync_mode,
  input logic [15:0] sync_pat,
  input logic [7:0]  cmd,
  input logic        hunt
);
  wire cw = wr_en & addr;

  p_ignore_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr) |=> ($stable(entry_state) && $stable(cmd) && $stable(sync_pat)));

  p_async_to_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && entry_state == 2'd1 && wdata[1:0] != 2'b00) |=> entry_state == 2'd0);

  p_sync_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && entry_state == 2'd1 && wdata[1:0] == 2'b00)
      |=> entry_state == ($past(wdata[7]) ? 2'd3 : 2'd2));

  p_first_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && entry_state == 2'd2) |=> (entry_state == 2'd3 && sync_pat[15:8] == $past(wdata)));

  p_second_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && entry_state == 2'd3) |=> (entry_state == 2'd0 && sync_pat[7:0] == $past(wdata)));

  p_ireset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && entry_state == 2'd0 && wdata[6]) |=> entry_state == 2'd1);

  p_hunt_sync_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hunt |-> sync_mode);

  p_clear_pat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && entry_state == 2'd1) |=> (sync_pat == 16'd0 && !hunt));
endmodule

bind usart_ctl_seq usart_ctl_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .entry_state(entry_state), .sync_mode(sync_mode), .sync_pat(sync_pat),
  .cmd(cmd), .hunt(hunt)
);

// File: tb/sim_usart_ctl_seq.sv
module sim_usart_ctl_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [1:0] entry_state;
  logic sync_mode, par_en, par_even, sync_single, ext_sync, hunt;
  logic [3:0] char_len;
  logic [1:0] stop_code;
  logic [6:0] clk_factor;
  logic [15:0] sync_pat;
  logic [7:0] cmd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usart_ctl_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .entry_state(entry_state), .sync_mode(sync_mode), .char_len(char_len),
    .par_en(par_en), .par_even(par_even), .stop_code(stop_code),
    .clk_factor(clk_factor), .sync_single(sync_single), .ext_sync(ext_sync),
    .sync_pat(sync_pat), .cmd(cmd), .hunt(hunt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 state", entry_state, 1);
    chk("R1 hunt", hunt, 0);
    chk("R1 cmd", cmd, 0);
    chk("R1 pat", sync_pat, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mb;
      bit s;
      logic [7:0] s1, s2;
      int st0;
      mb = m[7:0];
      s = (mb[1:0] == 2'b00);
      s1 = mb ^ 8'h5A;
      s2 = ~mb;
      wr(1'b1, mb);
      chk("R3 sync_mode", sync_mode, s);
      chk("R3 factor", clk_factor, (mb[1:0] == 2) ? 16 : (mb[1:0] == 3) ? 64 : 1);
      chk("R4 len", char_len, mb[3:2] + 5);
      chk("R5 par_en", par_en, mb[4]);
      chk("R5 par_even", par_even, mb[5]);
      chk("R6 stop", stop_code, s ? 0 : mb[7:6]);
      chk("R11 pat clear", sync_pat, 0);
      chk("R10 hunt clear", hunt, 0);
      if (!s) chk("R6 state", entry_state, 0);
      else begin
        chk("R7 ext", ext_sync, mb[6]);
        chk("R7 single", sync_single, mb[7]);
        chk("R7 state", entry_state, mb[7] ? 3 : 2);
        st0 = entry_state;
        wr(1'b0, 8'hFF);
        chk("R2 state", entry_state, st0);
        chk("R2 pat", sync_pat, 0);
        if (!mb[7]) begin
          wr(1'b1, s1);
          chk("R8 upper", sync_pat, {s1, 8'h00});
          chk("R8 state", entry_state, 3);
        end
        wr(1'b1, s2);
        chk("R8 lower", sync_pat, mb[7] ? {8'h00, s2} : {s1, s2});
        chk("R8 to cmd", entry_state, 0);
      end
      wr(1'b1, 8'h80 | mb[5:0]);
      chk("R9 cmd", cmd, 8'h80 | mb[5:0]);
      chk("R9 stay", entry_state, 0);
      chk("R10 hunt", hunt, s);
      wr(1'b0, 8'h00);
      chk("R2 cmd", cmd, 8'h80 | mb[5:0]);
      chk("R2 hunt", hunt, s);
      wr(1'b1, 8'h40);
      chk("R9 ireset", entry_state, 1);
      chk("R10 hunt off", hunt, 0);
      chk("R9 cmd2", cmd, 8'h40);
    end
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule